// File: doc/BRIEF.md
# Microcoded Multicycle Processor Control Sequencer

This block steers a multicycle 32-bit load/store datapath that uses one memory for both instruction and data traffic. A micro-program counter addresses a small microcode store. Each microinstruction holds two things: the full set of datapath control points for that cycle, and a sequencing operation that picks the next micro-address. The sequencing operation can return to the fetch state, step to the next micro-address, or jump to a routine chosen by the opcode.

Every instruction starts with a shared fetch step and a shared decode step. After decode, the sequencer runs the routine for the instruction class: register-register ALU, OR with immediate, load word, store word, or branch on equal. The branch compares its operands in one cycle and stores the ALU zero flag. In the next cycle the sequencer requests a conditional PC write and gates it with the stored flag. An opcode that no routine claims sends the sequencer straight back to fetch. The datapath, register file, memory and ALU lie outside this block.

Top module: `mseq_ctrl`

## Requirements

The control word is the vector {pc_wr_en, pc_cond_wr_en, pc_load, pc_src_sel, mem_addr_sel, mem_wr_en, instr_ld, dst_sel_rd, rf_wr_en, wb_from_mem, alu_a_from_reg, alu_b_sel[1:0], alu_op[1:0], imm_sign_ext}. The encodings are:
- alu_op: 00 = add, 01 = subtract, 10 = use the function field, 11 = OR.
- alu_b_sel: 00 = register B, 01 = constant 4, 10 = extended immediate, 11 = extended immediate shifted left by 2.

Any control point that a requirement does not name is 0.

- R1: A synchronous reset (rst high at a clock edge) sets state_o to 0 (fetch) at that edge. This also holds when the sequencer is in the middle of an instruction.
- R2: In state 0, instr_ld=1, pc_wr_en=1, pc_load=1, mem_addr_sel=0, alu_a_from_reg=0, alu_b_sel=01 and alu_op=00. The next state is always 1.
- R3: State 1 (decode) asserts no control point. It dispatches on opcode as follows: 000000 goes to state 4, 001101 to state 6, 100011 to state 8, 101011 to state 11 and 000100 to state 2.
- R4: The register-ALU routine runs two states. State 4 has alu_a_from_reg=1, alu_b_sel=00 and alu_op=10. State 5 has rf_wr_en=1 and dst_sel_rd=1. The sequencer then returns to state 0.
- R5: The OR-immediate routine runs two states. State 6 has alu_a_from_reg=1, alu_b_sel=10, alu_op=11 and imm_sign_ext=0. State 7 has rf_wr_en=1 and dst_sel_rd=0. The sequencer then returns to state 0.
- R6: The load routine runs three states. State 8 has alu_a_from_reg=1, alu_b_sel=10, alu_op=00 and imm_sign_ext=1. State 9 has mem_addr_sel=1 and no writes. State 10 has rf_wr_en=1, wb_from_mem=1 and dst_sel_rd=0. The sequencer then returns to state 0.
- R7: The store routine runs two states. State 11 has the same control word as state 8. State 12 has mem_addr_sel=1 and mem_wr_en=1. The sequencer then returns to state 0.
- R8: The branch routine runs two states. State 2 has alu_a_from_reg=1, alu_b_sel=00 and alu_op=01. State 3 has pc_cond_wr_en=1, pc_src_sel=1, alu_b_sel=11, alu_op=00 and imm_sign_ext=1. The sequencer then returns to state 0.
- R9: In state 3, pc_load equals the alu_zero value sampled at the clock edge that leaves state 2. Outside states 0 and 3, pc_load is 0.
- R10: An opcode that matches no routine moves the sequencer from state 1 to state 0. No register write and no memory write happen along the way.
- R11: alu_zero has no effect on the state sequence. It also has no effect on pc_load in state 3 once state 2 has ended.
- R12: rf_wr_en and mem_wr_en are never both 1.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| state_o | output | 4 | Current micro-address |
| pc_wr_en | output | 1 | Unconditional PC write request |
| pc_cond_wr_en | output | 1 | Conditional PC write request |
| pc_load | output | 1 | Resolved PC write enable |
| pc_src_sel | output | 1 | PC source: 0 sequential, 1 branch target |
| mem_addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| mem_wr_en | output | 1 | Memory write |
| instr_ld | output | 1 | Instruction register load |
| dst_sel_rd | output | 1 | Destination register: 1 rd field, 0 rt field |
| rf_wr_en | output | 1 | Register file write |
| wb_from_mem | output | 1 | Write-back data: 1 memory, 0 ALU |
| alu_a_from_reg | output | 1 | ALU A operand: 1 register A, 0 PC |
| alu_b_sel | output | 2 | ALU B operand select |
| alu_op | output | 2 | ALU operation class |
| imm_sign_ext | output | 1 | Immediate extension: 1 sign, 0 zero |

## Verification

The hardest case to reach from the ports is the branch decision. The bench has to make alu_zero disagree between the compare cycle and the target cycle. Only then does a check show that the stored flag decides the outcome and the live flag does not. The branch task therefore drives alu_zero during state 2 and flips it right after the sequencer enters state 3, in both directions. A second case that needs care is a reset that arrives in the middle of a routine. The bench raises reset while the load routine is in its address state.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    localparam int UA_W  = 4;
    localparam int OPC_W = 6;

    typedef logic [UA_W-1:0] uaddr_t;

    localparam uaddr_t ST_FETCH  = UA_W'(0);
    localparam uaddr_t ST_DECODE = UA_W'(1);
    localparam uaddr_t ST_BR_CMP = UA_W'(2);
    localparam uaddr_t ST_BR_TGT = UA_W'(3);
    localparam uaddr_t ST_R_EXE  = UA_W'(4);
    localparam uaddr_t ST_R_WB   = UA_W'(5);
    localparam uaddr_t ST_OR_EXE = UA_W'(6);
    localparam uaddr_t ST_OR_WB  = UA_W'(7);
    localparam uaddr_t ST_LW_ADR = UA_W'(8);
    localparam uaddr_t ST_LW_RD  = UA_W'(9);
    localparam uaddr_t ST_LW_WB  = UA_W'(10);
    localparam uaddr_t ST_SW_ADR = UA_W'(11);
    localparam uaddr_t ST_SW_WR  = UA_W'(12);

    localparam logic [1:0] ALU_ADD = 2'b00;
    localparam logic [1:0] ALU_SUB = 2'b01;
    localparam logic [1:0] ALU_FN  = 2'b10;
    localparam logic [1:0] ALU_OR  = 2'b11;

    localparam logic [1:0] BSEL_REG = 2'b00;
    localparam logic [1:0] BSEL_FOUR = 2'b01;
    localparam logic [1:0] BSEL_IMM = 2'b10;
    localparam logic [1:0] BSEL_IMM4 = 2'b11;

    typedef enum logic [1:0] {
        SEQ_ZERO = 2'd0,
        SEQ_INC  = 2'd1,
        SEQ_DISP = 2'd2
    } seq_op_e;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_cond;
        logic       pc_src;
        logic       addr_sel;
        logic       mem_wr;
        logic       instr_ld;
        logic       dst_rd;
        logic       rf_wr;
        logic       wb_mem;
        logic       a_reg;
        logic [1:0] b_sel;
        logic [1:0] alu_op;
        logic       sext;
        seq_op_e    seq;
    } uword_t;
endpackage

// File: rtl/mseq_rom.sv
module mseq_rom
    import mseq_pkg::*;
(
    input  uaddr_t addr,
    output uword_t uw
);
    always_comb begin
        uw     = '0;
        uw.seq = SEQ_ZERO;
        case (addr)
            ST_FETCH: begin
                uw.pc_wr    = 1'b1;
                uw.instr_ld = 1'b1;
                uw.b_sel    = BSEL_FOUR;
                uw.alu_op   = ALU_ADD;
                uw.seq      = SEQ_INC;
            end
            ST_DECODE: begin
                uw.seq = SEQ_DISP;
            end
            ST_BR_CMP: begin
                uw.a_reg  = 1'b1;
                uw.b_sel  = BSEL_REG;
                uw.alu_op = ALU_SUB;
                uw.seq    = SEQ_INC;
            end
            ST_BR_TGT: begin
                uw.pc_cond = 1'b1;
                uw.pc_src  = 1'b1;
                uw.b_sel   = BSEL_IMM4;
                uw.alu_op  = ALU_ADD;
                uw.sext    = 1'b1;
            end
            ST_R_EXE: begin
                uw.a_reg  = 1'b1;
                uw.b_sel  = BSEL_REG;
                uw.alu_op = ALU_FN;
                uw.seq    = SEQ_INC;
            end
            ST_R_WB: begin
                uw.rf_wr  = 1'b1;
                uw.dst_rd = 1'b1;
            end
            ST_OR_EXE: begin
                uw.a_reg  = 1'b1;
                uw.b_sel  = BSEL_IMM;
                uw.alu_op = ALU_OR;
                uw.seq    = SEQ_INC;
            end
            ST_OR_WB: begin
                uw.rf_wr = 1'b1;
            end
            ST_LW_ADR, ST_SW_ADR: begin
                uw.a_reg  = 1'b1;
                uw.b_sel  = BSEL_IMM;
                uw.alu_op = ALU_ADD;
                uw.sext   = 1'b1;
                uw.seq    = SEQ_INC;
            end
            ST_LW_RD: begin
                uw.addr_sel = 1'b1;
                uw.seq      = SEQ_INC;
            end
            ST_LW_WB: begin
                uw.rf_wr  = 1'b1;
                uw.wb_mem = 1'b1;
            end
            ST_SW_WR: begin
                uw.addr_sel = 1'b1;
                uw.mem_wr   = 1'b1;
            end
            default: begin
                uw.seq = SEQ_ZERO;
            end
        endcase
    end
endmodule

// File: rtl/mseq_dispatch.sv
module mseq_dispatch
    import mseq_pkg::*;
#(
    parameter logic [OPC_W-1:0] OPC_RTYPE = 6'b000000,
    parameter logic [OPC_W-1:0] OPC_ORI   = 6'b001101,
    parameter logic [OPC_W-1:0] OPC_LW    = 6'b100011,
    parameter logic [OPC_W-1:0] OPC_SW    = 6'b101011,
    parameter logic [OPC_W-1:0] OPC_BEQ   = 6'b000100
) (
    input  logic [OPC_W-1:0] opcode,
    output uaddr_t           tgt
);
    always_comb begin
        if (opcode == OPC_RTYPE)     tgt = ST_R_EXE;
        else if (opcode == OPC_ORI)  tgt = ST_OR_EXE;
        else if (opcode == OPC_LW)   tgt = ST_LW_ADR;
        else if (opcode == OPC_SW)   tgt = ST_SW_ADR;
        else if (opcode == OPC_BEQ)  tgt = ST_BR_CMP;
        else                         tgt = ST_FETCH;
    end
endmodule

// File: rtl/mseq_next.sv
module mseq_next
    import mseq_pkg::*;
(
    input  seq_op_e op,
    input  uaddr_t  upc,
    input  uaddr_t  disp_tgt,
    output uaddr_t  nxt
);
    always_comb begin
        case (op)
            SEQ_INC:  nxt = upc + UA_W'(1);
            SEQ_DISP: nxt = disp_tgt;
            default:  nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
    import mseq_pkg::*;
#(
    parameter logic [OPC_W-1:0] OPC_RTYPE = 6'b000000,
    parameter logic [OPC_W-1:0] OPC_ORI   = 6'b001101,
    parameter logic [OPC_W-1:0] OPC_LW    = 6'b100011,
    parameter logic [OPC_W-1:0] OPC_SW    = 6'b101011,
    parameter logic [OPC_W-1:0] OPC_BEQ   = 6'b000100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic             alu_zero,
    output logic [UA_W-1:0]  state_o,
    output logic             pc_wr_en,
    output logic             pc_cond_wr_en,
    output logic             pc_load,
    output logic             pc_src_sel,
    output logic             mem_addr_sel,
    output logic             mem_wr_en,
    output logic             instr_ld,
    output logic             dst_sel_rd,
    output logic             rf_wr_en,
    output logic             wb_from_mem,
    output logic             alu_a_from_reg,
    output logic [1:0]       alu_b_sel,
    output logic [1:0]       alu_op,
    output logic             imm_sign_ext
);
    typedef struct packed {
        uaddr_t upc;
        logic   eq;
    } ctl_t;

    ctl_t   ctl_d, ctl_q;
    uword_t uw;
    uaddr_t disp_tgt;
    uaddr_t nxt_addr;

    mseq_rom i_rom (
        .addr (ctl_q.upc),
        .uw   (uw)
    );

    mseq_dispatch #(
        .OPC_RTYPE (OPC_RTYPE),
        .OPC_ORI   (OPC_ORI),
        .OPC_LW    (OPC_LW),
        .OPC_SW    (OPC_SW),
        .OPC_BEQ   (OPC_BEQ)
    ) i_disp (
        .opcode (opcode),
        .tgt    (disp_tgt)
    );

    mseq_next i_next (
        .op       (uw.seq),
        .upc      (ctl_q.upc),
        .disp_tgt (disp_tgt),
        .nxt      (nxt_addr)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.upc = nxt_addr;
        if (ctl_q.upc == ST_BR_CMP) begin
            ctl_d.eq = alu_zero;
        end
        if (rst) begin
            ctl_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign state_o        = ctl_q.upc;
    assign pc_wr_en       = uw.pc_wr;
    assign pc_cond_wr_en  = uw.pc_cond;
    assign pc_load        = uw.pc_wr | (uw.pc_cond & ctl_q.eq);
    assign pc_src_sel     = uw.pc_src;
    assign mem_addr_sel   = uw.addr_sel;
    assign mem_wr_en      = uw.mem_wr;
    assign instr_ld       = uw.instr_ld;
    assign dst_sel_rd     = uw.dst_rd;
    assign rf_wr_en       = uw.rf_wr;
    assign wb_from_mem    = uw.wb_mem;
    assign alu_a_from_reg = uw.a_reg;
    assign alu_b_sel      = uw.b_sel;
    assign alu_op         = uw.alu_op;
    assign imm_sign_ext   = uw.sext;
endmodule

// File: rtl/mseq_ctrl_chk.sv
module mseq_ctrl_chk
    import mseq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [UA_W-1:0] state_o,
    input logic            pc_wr_en,
    input logic            pc_load,
    input logic            instr_ld,
    input logic            rf_wr_en,
    input logic            mem_wr_en
);
    AST_RST_TO_FETCH: assert property (@(posedge clk) rst |=> state_o == ST_FETCH); // R1

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_FETCH |=> state_o == ST_DECODE); // R2

    AST_IR_ONLY_IN_FETCH: assert property (@(posedge clk) disable iff (rst)
        instr_ld |-> (state_o == ST_FETCH && pc_wr_en)); // R2

    AST_DISPATCH_LEGAL: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_DECODE |=> (state_o == ST_FETCH || state_o == ST_BR_CMP ||
                                  state_o == ST_R_EXE || state_o == ST_OR_EXE ||
                                  state_o == ST_LW_ADR || state_o == ST_SW_ADR)); // R3

    AST_LOAD_CHAIN: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_LW_ADR |=> state_o == ST_LW_RD); // R6

    AST_ROUTINE_END: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_R_WB || state_o == ST_OR_WB || state_o == ST_LW_WB ||
         state_o == ST_SW_WR || state_o == ST_BR_TGT) |=> state_o == ST_FETCH); // R4

    AST_COND_LOAD_ONLY_BRANCH: assert property (@(posedge clk) disable iff (rst)
        (pc_load && !pc_wr_en) |-> state_o == ST_BR_TGT); // R9

    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(rf_wr_en && mem_wr_en)); // R12
endmodule

bind mseq_ctrl mseq_ctrl_chk i_mseq_ctrl_chk (
    .clk       (clk),
    .rst       (rst),
    .state_o   (state_o),
    .pc_wr_en  (pc_wr_en),
    .pc_load   (pc_load),
    .instr_ld  (instr_ld),
    .rf_wr_en  (rf_wr_en),
    .mem_wr_en (mem_wr_en)
);

// File: tb/test_mseq_ctrl.sv
`timescale 1ns/1ps
module test_mseq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic       alu_zero = 1'b0;
    logic [3:0] state_o;
    logic pc_wr_en, pc_cond_wr_en, pc_load, pc_src_sel, mem_addr_sel, mem_wr_en;
    logic instr_ld, dst_sel_rd, rf_wr_en, wb_from_mem, alu_a_from_reg, imm_sign_ext;
    logic [1:0] alu_b_sel, alu_op;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mseq_ctrl i_mseq_ctrl (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
        .state_o(state_o), .pc_wr_en(pc_wr_en), .pc_cond_wr_en(pc_cond_wr_en),
        .pc_load(pc_load), .pc_src_sel(pc_src_sel), .mem_addr_sel(mem_addr_sel),
        .mem_wr_en(mem_wr_en), .instr_ld(instr_ld), .dst_sel_rd(dst_sel_rd),
        .rf_wr_en(rf_wr_en), .wb_from_mem(wb_from_mem),
        .alu_a_from_reg(alu_a_from_reg), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
        .imm_sign_ext(imm_sign_ext)
    );

    // order: pcw pcc pcl src adr mw il drd rfw wbm ar bsel[2] aop[2] sx
    function automatic logic [15:0] mk(input logic pcw, pcc, pcl, src, adr, mw, il,
                                       drd, rfw, wbm, ar, input logic [1:0] bs,
                                       input logic [1:0] ao, input logic sx);
        return {pcw, pcc, pcl, src, adr, mw, il, drd, rfw, wbm, ar, bs, ao, sx};
    endfunction

    wire [15:0] act_word = {pc_wr_en, pc_cond_wr_en, pc_load, pc_src_sel, mem_addr_sel,
                            mem_wr_en, instr_ld, dst_sel_rd, rf_wr_en, wb_from_mem,
                            alu_a_from_reg, alu_b_sel, alu_op, imm_sign_ext};

    localparam logic [15:0] W_FETCH  = 16'b1010001000_0_01_00_0;
    localparam logic [15:0] W_IDLE   = 16'd0;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [3:0] es, input logic [15:0] ew);
        n_chk++;
        if (state_o !== es || act_word !== ew) begin
            n_bad++;
            $display("FAIL %s: state=%0d word=%b expected state=%0d word=%b",
                     tag, state_o, act_word, es, ew);
        end
    endtask

    task automatic fetch_decode(input string tag, input logic [5:0] op);
        opcode = op;
        chk({tag, " R2 fetch"}, 4'd0, mk(1,0,1,0,0,0,1,0,0,0,0,2'b01,2'b00,0));
        step();
        chk({tag, " R3 decode"}, 4'd1, W_IDLE);
        step();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        chk("R1 reset state", 4'd0, W_FETCH);
    endtask

    task automatic t_rtype();
        fetch_decode("rtype", 6'b000000);
        chk("R4 exec", 4'd4, mk(0,0,0,0,0,0,0,0,0,0,1,2'b00,2'b10,0));
        step();
        chk("R4 writeback", 4'd5, mk(0,0,0,0,0,0,0,1,1,0,0,2'b00,2'b00,0));
        step();
        chk("R4 return", 4'd0, W_FETCH);
    endtask

    task automatic t_ori();
        fetch_decode("ori", 6'b001101);
        chk("R5 exec", 4'd6, mk(0,0,0,0,0,0,0,0,0,0,1,2'b10,2'b11,0));
        step();
        chk("R5 writeback", 4'd7, mk(0,0,0,0,0,0,0,0,1,0,0,2'b00,2'b00,0));
        step();
        chk("R5 return", 4'd0, W_FETCH);
    endtask

    task automatic t_lw();
        fetch_decode("lw", 6'b100011);
        chk("R6 address", 4'd8, mk(0,0,0,0,0,0,0,0,0,0,1,2'b10,2'b00,1));
        step();
        chk("R6 read", 4'd9, mk(0,0,0,0,1,0,0,0,0,0,0,2'b00,2'b00,0));
        step();
        chk("R6 writeback", 4'd10, mk(0,0,0,0,0,0,0,0,1,1,0,2'b00,2'b00,0));
        step();
        chk("R6 return", 4'd0, W_FETCH);
    endtask

    task automatic t_sw();
        fetch_decode("sw", 6'b101011);
        chk("R7 address", 4'd11, mk(0,0,0,0,0,0,0,0,0,0,1,2'b10,2'b00,1));
        step();
        chk("R7 write", 4'd12, mk(0,0,0,0,1,1,0,0,0,0,0,2'b00,2'b00,0));
        n_chk++;
        if (rf_wr_en && mem_wr_en) begin
            n_bad++;
            $display("FAIL R12 single write: rf=%b mem=%b expected not both", rf_wr_en, mem_wr_en);
        end
        step();
        chk("R7 return", 4'd0, W_FETCH);
    endtask

    // zero_cmp: flag during compare; zero_late: flag driven once in target state
    task automatic t_beq(input logic zero_cmp, input logic zero_late);
        fetch_decode("beq", 6'b000100);
        alu_zero = zero_cmp;
        chk("R8 compare", 4'd2, mk(0,0,0,0,0,0,0,0,0,0,1,2'b00,2'b01,0));
        step();
        alu_zero = zero_late;
        #0.5;
        chk("R9 R11 target", 4'd3, mk(0,1,zero_cmp,1,0,0,0,0,0,0,0,2'b11,2'b00,1));
        step();
        chk("R8 return", 4'd0, W_FETCH);
        alu_zero = 1'b0;
    endtask

    task automatic t_bad_op();
        alu_zero = 1'b1;
        fetch_decode("bad", 6'b111111);
        chk("R10 unknown opcode back to fetch", 4'd0, W_FETCH);
        alu_zero = 1'b0;
    endtask

    task automatic t_reset_mid();
        fetch_decode("lw", 6'b100011);
        chk("R6 address before reset", 4'd8, mk(0,0,0,0,0,0,0,0,0,0,1,2'b10,2'b00,1));
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R1 reset mid routine", 4'd0, W_FETCH);
    endtask

    initial begin
        #1;
        t_reset();
        t_rtype();
        t_ori();
        t_lw();
        t_sw();
        t_beq(1'b1, 1'b0);
        t_beq(1'b0, 1'b1);
        t_bad_op();
        t_reset_mid();
        t_rtype();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule